// File: doc/BRIEF.md
# ATM Header Error Check Generator

This block sits in the transmit direction of a cell processor. It takes 53-octet cells one octet per clock and writes a header error check (HEC) into octet 5 of each cell. A start-of-cell strobe marks octet 1. An idle flag, sampled together with that strobe, tells the block whether the cell is an idle cell or a valid cell. The check is a CRC-8 taken over header octets 1 to 4. The block can also apply a coset XOR to the result. Valid cells and idle cells are enabled separately. An idle cell whose HEC calculation is turned off receives a fifth octet from a programmable register. Every other octet leaves the block unchanged, one clock after it entered.

A two-register configuration port holds the settings. Address 0 is the control register and address 1 holds the idle-cell fallback octet. The block copies the settings at each start of cell and uses that copy for the whole cell. Because of this, software may write the registers at any time.

Top module: `atm_hec_inserter`

## Requirements
- R1: After reset, the control register (address 0) reads 0x62 and the idle fallback register (address 1) reads 0x00. In the control register, bit 6 is coset enable, bit 5 is valid-cell HEC enable and bit 1 is idle-cell HEC enable. All other control bits read 0.
- R2: For a valid cell with bit 5 set and bit 6 clear, output octet 5 is the CRC-8 of octets 1 to 4. The CRC uses generator x^8+x^2+x+1 (0x07), starts from zero at octet 1 and takes each octet MSB first.
- R3: With bit 6 set, the inserted value is that CRC-8 XORed with 0x55.
- R4: For a valid cell with bit 5 clear, output octet 5 equals the octet 5 that was received.
- R5: For an idle cell (in_idle high with the start strobe) with bit 1 set, output octet 5 is the CRC-8 of its four header octets, with the coset applied when bit 6 is set.
- R6: For an idle cell with bit 1 clear, output octet 5 equals the value in the address-1 register. The received octet 5 is ignored.
- R7: Octets 1 to 4 and 6 to 53 leave unchanged exactly one clock after entry. out_valid and out_soc follow in_valid and the start strobe with the same one-clock delay.
- R8: The block samples the configuration in the clock cycle that carries the start strobe. A register write made in that cycle or later in the cell takes effect only from the next cell.
- R9: With default settings, a valid cell with an all-zero header gets 0x55 in octet 5. An idle cell with header 00 00 00 01 gets 0x52.
- R10: Cycles with in_valid low neither advance the octet position nor change the CRC. While in_valid is low, out_valid is low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 control, 1 idle fallback octet |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the selected register (combinational) |
| in_valid | input | 1 | Input octet is valid |
| in_soc | input | 1 | Input octet is octet 1 of a cell |
| in_idle | input | 1 | Cell is an idle cell; sampled with in_soc |
| in_data | input | 8 | Input octet |
| out_valid | output | 1 | Output octet is valid |
| out_soc | output | 1 | Output octet is octet 1 of a cell |
| out_data | output | 8 | Output octet |

## Verification
A wrong CRC state, a wrong octet count or wrong latched settings first appear in the octet 5 that reaches the output. That happens at the latest five valid octets after the start strobe. An octet counter that slips also corrupts a header or payload octet, which is detected one clock after entry. The stimulus puts gaps between octets and writes the registers in the middle of a cell, so a position that advances during a gap, or a setting that is used before the next boundary, appears in that same cell's octet 5.

// File: rtl/hec_pkg.sv
// Package shared by the HEC inserter: cell geometry, register reset values
// and the byte-serial CRC-8 step. Assumes 8-bit octets, MSB sent first.
package hec_pkg;
    localparam int OCT_W       = 8;
    localparam int CELL_OCTETS = 53;
    localparam int HDR_OCTETS  = 4;
    localparam int HEC_POS     = HDR_OCTETS + 1;
    localparam int POS_W       = $clog2(CELL_OCTETS + 2);
    localparam logic [POS_W-1:0] POS_NONE = '1;
    localparam logic [OCT_W-1:0] CRC_POLY = 8'h07;
    localparam logic [OCT_W-1:0] COSET    = 8'h55;
    localparam int BIT_COSET = 6;
    localparam int BIT_VINS  = 5;
    localparam int BIT_ICALC = 1;

    typedef struct packed {
        logic coset;
        logic valid_ins;
        logic idle_calc;
    } hec_cfg_t;

    localparam hec_cfg_t CFG_RESET = '{coset: 1'b1, valid_ins: 1'b1, idle_calc: 1'b1};

    // Advance a CRC-8 by one octet, MSB first.
    function automatic logic [OCT_W-1:0] crc8_step(input logic [OCT_W-1:0] crc,
                                                   input logic [OCT_W-1:0] d);
        logic [OCT_W-1:0] c;
        logic fb;
        c = crc;
        for (int i = OCT_W - 1; i >= 0; i--) begin
            fb = c[OCT_W-1] ^ d[i];
            c  = {c[OCT_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction
endpackage

// File: rtl/hec_cfg_regs.sv
// Configuration registers: control bits at address 0 and the idle-cell
// fallback octet at address 1. Reads are combinational. Assumes one write
// per cycle at most.
module hec_cfg_regs
    import hec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_addr,
    input  logic [OCT_W-1:0] cfg_wdata,
    output logic [OCT_W-1:0] cfg_rdata,
    output hec_cfg_t         cfg,
    output logic [OCT_W-1:0] idle_b5
);
    // Hold the control bits and fallback octet; load on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= CFG_RESET;
            idle_b5 <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr) begin
                idle_b5 <= cfg_wdata;
            end else begin
                cfg.coset     <= cfg_wdata[BIT_COSET];
                cfg.valid_ins <= cfg_wdata[BIT_VINS];
                cfg.idle_calc <= cfg_wdata[BIT_ICALC];
            end
        end
    end

    // Read mux; unused control bits read as zero.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr) begin
            cfg_rdata = idle_b5;
        end else begin
            cfg_rdata[BIT_COSET] = cfg.coset;
            cfg_rdata[BIT_VINS]  = cfg.valid_ins;
            cfg_rdata[BIT_ICALC] = cfg.idle_calc;
        end
    end
endmodule

// File: rtl/hec_octet_tracker.sv
// Tracks the octet position within a cell and accumulates the CRC over the
// header octets. cur_idx gives the position (1..53) of the octet currently
// presented. It is 0 when in_valid is low and POS_NONE outside any cell.
// Assumes every cell starts with in_soc.
module hec_octet_tracker
    import hec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_soc,
    input  logic [OCT_W-1:0] in_data,
    output logic [POS_W-1:0] cur_idx,
    output logic [OCT_W-1:0] crc_q
);
    logic [POS_W-1:0] pos_q;

    // Position of the present octet, derived from the last accepted one.
    always_comb begin
        if (!in_valid)
            cur_idx = '0;
        else if (in_soc)
            cur_idx = POS_W'(1);
        else if (pos_q >= POS_W'(CELL_OCTETS))
            cur_idx = POS_NONE;
        else
            cur_idx = pos_q + POS_W'(1);
    end

    // Remember the position of the last accepted octet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= POS_NONE;
        else if (in_valid)
            pos_q <= cur_idx;
    end

    // Fold header octets into the CRC; restart at octet 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= '0;
        else if (in_valid && cur_idx >= POS_W'(1) && cur_idx <= POS_W'(HDR_OCTETS))
            crc_q <= crc8_step((cur_idx == POS_W'(1)) ? '0 : crc_q, in_data);
    end
endmodule

// File: rtl/hec_out_stage.sv
// Output register stage. Latches the cell's settings at the start strobe and
// replaces octet 5 according to them. All other octets pass through with one
// clock of delay.
module hec_out_stage
    import hec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  hec_cfg_t         cfg,
    input  logic [OCT_W-1:0] idle_b5,
    input  logic             in_valid,
    input  logic             in_soc,
    input  logic             in_idle,
    input  logic [OCT_W-1:0] in_data,
    input  logic [POS_W-1:0] cur_idx,
    input  logic [OCT_W-1:0] crc_q,
    output logic             out_valid,
    output logic             out_soc,
    output logic [OCT_W-1:0] out_data
);
    hec_cfg_t         cell_cfg;
    logic             cell_idle;
    logic [OCT_W-1:0] cell_b5;
    logic [OCT_W-1:0] hec_val;
    logic [OCT_W-1:0] oct5_val;

    // Freeze the settings for the cell at its start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_cfg  <= CFG_RESET;
            cell_idle <= 1'b0;
            cell_b5   <= '0;
        end else if (in_valid && in_soc) begin
            cell_cfg  <= cfg;
            cell_idle <= in_idle;
            cell_b5   <= idle_b5;
        end
    end

    // Choose the fifth octet from the frozen settings.
    always_comb begin
        hec_val = crc_q ^ (cell_cfg.coset ? COSET : '0);
        if (cell_idle)
            oct5_val = cell_cfg.idle_calc ? hec_val : cell_b5;
        else
            oct5_val = cell_cfg.valid_ins ? hec_val : in_data;
    end

    // One-clock output register for data and framing flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_soc   <= in_valid && in_soc;
            out_data  <= (in_valid && cur_idx == POS_W'(HEC_POS)) ? oct5_val : in_data;
        end
    end
endmodule

// File: rtl/atm_hec_inserter.sv
// Top level of the HEC generator and inserter: configuration registers, octet
// tracker and output stage. Assumes one octet per clock when in_valid is high.
module atm_hec_inserter
    import hec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_addr,
    input  logic [OCT_W-1:0] cfg_wdata,
    output logic [OCT_W-1:0] cfg_rdata,
    input  logic             in_valid,
    input  logic             in_soc,
    input  logic             in_idle,
    input  logic [OCT_W-1:0] in_data,
    output logic             out_valid,
    output logic             out_soc,
    output logic [OCT_W-1:0] out_data
);
    hec_cfg_t         cfg;
    logic [OCT_W-1:0] idle_b5;
    logic [POS_W-1:0] cur_idx;
    logic [OCT_W-1:0] crc_q;

    hec_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg(cfg), .idle_b5(idle_b5)
    );

    hec_octet_tracker u_trk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
        .in_data(in_data), .cur_idx(cur_idx), .crc_q(crc_q)
    );

    hec_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .idle_b5(idle_b5),
        .in_valid(in_valid), .in_soc(in_soc), .in_idle(in_idle), .in_data(in_data),
        .cur_idx(cur_idx), .crc_q(crc_q),
        .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data)
    );
endmodule

// File: rtl/atm_hec_inserter_chk.sv
// Property checker attached to the HEC inserter top level by bind.
module atm_hec_inserter_chk
    import hec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_soc,
    input logic [OCT_W-1:0] in_data,
    input logic [POS_W-1:0] cur_idx,
    input logic [OCT_W-1:0] crc_q,
    input logic             out_valid,
    input logic             out_soc,
    input logic [OCT_W-1:0] out_data
);
    // R7
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R10
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7
    soc_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_soc) |=> out_soc);
    // R7
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_idx != POS_W'(HEC_POS)) |=> out_data == $past(in_data));
    // R10
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(crc_q));
    // R2
    crc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_soc) |=> crc_q == crc8_step('0, $past(in_data)));
endmodule

bind atm_hec_inserter atm_hec_inserter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
    .in_data(in_data), .cur_idx(cur_idx), .crc_q(crc_q),
    .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data)
);

// File: tb/atm_hec_inserter_test.sv
module atm_hec_inserter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       in_valid = 1'b0;
    logic       in_soc = 1'b0;
    logic       in_idle = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid;
    logic       out_soc;
    logic [7:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    bit m_cos = 1, m_vins = 1, m_icalc = 1;
    logic [7:0] m_b5 = 8'h00;

    always #10 clk = ~clk;

    atm_hec_inserter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_soc(in_soc), .in_idle(in_idle), .in_data(in_data),
        .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data)
    );

    // Reference CRC-8 as polynomial division of the 32-bit header.
    function automatic logic [7:0] ref_hec(input logic [31:0] hdr);
        logic [39:0] r;
        r = {hdr, 8'h00};
        for (int i = 39; i >= 8; i--)
            if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
        return r[7:0];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply the register write to the bench copy of the settings.
    task automatic model_wr(input bit a, input logic [7:0] d);
        if (a) m_b5 = d;
        else begin m_cos = d[6]; m_vins = d[5]; m_icalc = d[1]; end
    endtask

    // One clock: drive at the negedge, check the outputs at the following negedge.
    task automatic step(input bit v, input bit s, input bit idl, input logic [7:0] d,
                        input bit wr, input bit wa, input logic [7:0] wd,
                        input logic [7:0] exp, input string tag);
        in_valid = v; in_soc = s; in_idle = idl; in_data = d;
        cfg_wr = wr; cfg_addr = wa; cfg_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0; in_soc = 0; cfg_wr = 0;
        if (wr) model_wr(wa, wd);
        if (!v) check(out_valid == 1'b0, "R10 gap", {7'd0, out_valid}, 8'h00);
        else begin
            check(out_valid && out_data == exp, tag, out_data, exp);
            if (s) check(out_soc == 1'b1, "R7 soc", {7'd0, out_soc}, 8'h01);
        end
    endtask

    task automatic write_reg(input bit a, input logic [7:0] d);
        step(0, 0, 0, 8'h00, 1, a, d, 8'h00, "R10 idle");
    endtask

    // Send one cell; wr_at selects the octet that carries a register write (0 none).
    task automatic send_cell(input bit idl, input logic [31:0] hdr, input int wr_at,
                             input bit wa, input logic [7:0] wd, input int gap_pct,
                             input string t5);
        bit cos, vins, icalc;
        logic [7:0] b5, hec, r5, d, e;
        string tag;
        cos = m_cos; vins = m_vins; icalc = m_icalc; b5 = m_b5;
        hec = ref_hec(hdr) ^ (cos ? 8'h55 : 8'h00);
        r5 = 8'($urandom);
        for (int k = 1; k <= 53; k++) begin
            while ((k > 1) && (int'($urandom_range(99)) < gap_pct))
                step(0, 0, 0, 8'($urandom), 0, 0, 8'h00, 8'h00, "R10");
            if (k <= 4) d = hdr[39 - 8*k -: 8];
            else if (k == 5) d = r5;
            else d = 8'($urandom);
            e = d; tag = "R7 pass";
            if (k == 5) begin
                tag = t5;
                if (idl) e = icalc ? hec : b5;
                else     e = vins ? hec : r5;
            end
            step(1, k == 1, idl, d, k == wr_at, wa, wd, e, tag);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c3d5a7b));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        cfg_addr = 0; #1;
        check(cfg_rdata == 8'h62, "R1 ctrl", cfg_rdata, 8'h62);
        cfg_addr = 1; #1;
        check(cfg_rdata == 8'h00, "R1 b5", cfg_rdata, 8'h00);
        @(negedge clk);
        // R9 self-check values with default settings
        send_cell(0, 32'h0000_0000, 0, 0, 0, 0, "R9 zero hdr");
        send_cell(1, 32'h0000_0001, 0, 0, 0, 0, "R9 idle hdr");
        // R3 coset on, random header, with gaps
        send_cell(0, 32'h1234_5678, 0, 0, 0, 30, "R3 coset");
        // R2 coset off
        write_reg(0, 8'h22);
        send_cell(0, 32'hdead_beef, 0, 0, 0, 10, "R2 plain crc");
        // R4 valid insertion off
        write_reg(0, 8'h42);
        send_cell(0, 32'hcafe_f00d, 0, 0, 0, 0, "R4 pass oct5");
        // R5 idle calc on with coset
        send_cell(1, 32'h0000_0001, 0, 0, 0, 20, "R5 idle hec");
        // R6 idle calc off, fallback octet
        write_reg(1, 8'ha7);
        write_reg(0, 8'h60);
        cfg_addr = 1; #1;
        check(cfg_rdata == 8'ha7, "R6 b5 readback", cfg_rdata, 8'ha7);
        @(negedge clk);
        send_cell(1, 32'h0000_0001, 0, 0, 0, 0, "R6 fallback");
        // R8 writes at the start strobe and mid-cell do not affect the cell
        send_cell(1, 32'h0000_0001, 1, 0, 8'h62, 0, "R8 soc write");
        send_cell(0, 32'h0102_0304, 3, 0, 8'h00, 15, "R8 mid write");
        send_cell(1, 32'h0a0b_0c0d, 4, 1, 8'h3c, 0, "R8 mid b5 write");
        // Random traffic with random settings between cells
        for (int c = 0; c < 60; c++) begin
            bit idl;
            if ($urandom_range(2) == 0) write_reg(0, 8'($urandom));
            if ($urandom_range(3) == 0) write_reg(1, 8'($urandom));
            idl = bit'($urandom_range(1));
            send_cell(idl, $urandom, 0, 0, 0, int'($urandom_range(25)),
                      idl ? (m_icalc ? "R5 rand" : "R6 rand")
                          : (m_vins ? (m_cos ? "R3 rand" : "R2 rand") : "R4 rand"));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule